// File: doc/BRIEF.md
# Nibble-Serial Clock Register Master

This block moves single 4-bit values between a host and a sixteen-register timekeeping device over three wires: a serial clock, one data line that changes direction, and a chip enable that the system supplies on its own. Each transfer is one frame of sixteen serial bits. A read frame has a command nibble and an address nibble, then turns the line around. The device then returns four filler bits and four data bits. A write frame has a command nibble, the address nibble, a second command nibble and the data nibble, and the block drives the line for the whole frame.

The host hands in one request at a time on a valid/ready channel and gets a one-cycle completion pulse back. For a read, the returned nibble comes with that pulse. The serial clock runs at a rate set by a half-period parameter counted in system clocks. Every bit has a high phase followed by a low phase. Outgoing data changes at the start of the high phase. Incoming data is sampled at the last system clock before the falling edge.

Back-pressure rules: a request transfers on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no frame is in progress. The request fields are captured on the transfer cycle and need not be held afterwards. The completion channel has no back-pressure: `rsp_valid` is a single-cycle pulse, and the host must take `rsp_rdata` on that cycle.

Top module: `nsm_master`

## Requirements
- R1: Out of reset and whenever idle, the serial clock is high, the data output is high, the data output enable is high, `req_ready` is high and `rsp_valid` is low.
- R2: While a frame is in progress `req_ready` is low, and `req_valid` has no effect: no second frame starts and the device contents are left unchanged.
- R3: A read frame drives, first bit first, the command bits 1,1,1,0 and then the address from its most significant bit down.
- R4: In a read frame the output enable drops at bit 8 and stays low to the end of the frame. Bits 8 to 11 are discarded. Bits 12 to 15 form the returned nibble, most significant bit first, each sampled at the last system clock before that bit's falling edge.
- R5: A write frame drives, first bit first, 1,0,1,0, then the address MSB first, then 1,0,0,1, then the data MSB first. The output enable stays high throughout.
- R6: Every frame has exactly 16 serial clock pulses. Each low phase lasts exactly `HALF_CLKS` system clocks.
- R7: `rsp_valid` is high for exactly one cycle, `33*HALF_CLKS` clock edges after the edge that accepted the request. For a read, `rsp_rdata` holds the returned nibble in that cycle.
- R8: A synchronous active-high reset asserted in the middle of a frame returns the block at once to the R1 idle state, and a following transfer completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_addr | input | 4 | Device register index |
| req_wdata | input | 4 | Nibble to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Nibble returned by a read |
| rtc_sclk | output | 1 | Serial clock, idles high |
| rtc_sdo | output | 1 | Serial data driven toward the device |
| rtc_sdo_oe | output | 1 | 1 = block drives the data line, 0 = device drives it |
| rtc_sdi | input | 1 | Serial data read back from the line |

## Verification
The bench builds the block with `HALF_CLKS` set to 2, so a full frame takes 66 system clocks. That leaves room for a table of mixed writes and read-backs, and for directed runs of a request held during a busy frame and a reset in the middle of a frame. Because a half period of 2 is larger than one clock, the phase counter has to count and wrap, so mistakes in phase length and in the sampling point show up. A device model in the bench drives the inverse of the stored nibble during the four filler bits, so a capture window shifted by even one bit returns a wrong value.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
  localparam int NIB_W      = 4;
  localparam int FRAME_BITS = 16;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int TURN_BIT   = 8;   // first device-driven bit of a read
  localparam int CAPT_BIT   = 12;  // first returned data bit of a read

  localparam logic [NIB_W-1:0] CMD_RD  = 4'b1110;
  localparam logic [NIB_W-1:0] CMD_WR  = 4'b1010;
  localparam logic [NIB_W-1:0] CMD_DAT = 4'b1001;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HIGH,
    ST_LOW,
    ST_TAIL
  } nsm_state_e;
endpackage

// File: rtl/nsm_tick.sv
// Phase timer: flags the last system clock of a serial half period.
module nsm_tick #(
  parameter int HALF_CLKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic last
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == CW'(HALF_CLKS - 1));

  a_r6_phase_bound: assert property (@(posedge clk) disable iff (rst)
    !restart |-> (int'(cnt_q) < HALF_CLKS));
endmodule

// File: rtl/nsm_frame.sv
// Frame decoder: value, drive direction and capture flag for one bit slot.
module nsm_frame
  import nsm_pkg::*;
(
  input  logic             is_write,
  input  logic [NIB_W-1:0] addr,
  input  logic [NIB_W-1:0] wdata,
  input  logic [BIT_W-1:0] bit_idx,
  output logic             bit_val,
  output logic             drive,
  output logic             capture
);
  logic [FRAME_BITS-1:0] wr_pat, rd_pat, seq;

  assign wr_pat = {CMD_WR, addr, CMD_DAT, wdata};
  assign rd_pat = {CMD_RD, addr, {(FRAME_BITS-2*NIB_W){1'b1}}};

  // seq[i] is the level driven in slot i (slot 0 goes out first)
  for (genvar i = 0; i < FRAME_BITS; i++) begin : g_slot
    assign seq[i] = is_write ? wr_pat[FRAME_BITS-1-i] : rd_pat[FRAME_BITS-1-i];
  end

  assign bit_val = seq[bit_idx];
  assign drive   = is_write || (int'(bit_idx) < TURN_BIT);
  assign capture = !is_write && (int'(bit_idx) >= CAPT_BIT);
endmodule

// File: rtl/nsm_master.sv
module nsm_master
  import nsm_pkg::*;
#(
  parameter int HALF_CLKS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [NIB_W-1:0] req_addr,
  input  logic [NIB_W-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [NIB_W-1:0] rsp_rdata,
  output logic             rtc_sclk,
  output logic             rtc_sdo,
  output logic             rtc_sdo_oe,
  input  logic             rtc_sdi
);
  nsm_state_e       state_q, state_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic             wr_q, wr_n;
  logic [NIB_W-1:0] addr_q, addr_n, wdat_q, wdat_n;
  logic [NIB_W-1:0] shreg_q;
  logic             capt_q, done_q;
  logic             sclk_q, sdo_q, oe_q;
  logic             accept, last, restart;
  logic             nxt_val, nxt_drv, nxt_capt;

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_n = state_q;
    bit_n   = bit_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        state_n = ST_HIGH;
        bit_n   = '0;
      end
      ST_HIGH: if (last) state_n = ST_LOW;
      ST_LOW: if (last) begin
        if (bit_q == BIT_W'(FRAME_BITS - 1)) state_n = ST_TAIL;
        else begin
          state_n = ST_HIGH;
          bit_n   = bit_q + 1'b1;
        end
      end
      ST_TAIL: if (last) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  assign wr_n   = accept ? req_write : wr_q;
  assign addr_n = accept ? req_addr  : addr_q;
  assign wdat_n = accept ? req_wdata : wdat_q;

  // every phase ends with a state change; idle keeps the timer parked
  assign restart = (state_n != state_q) || (state_q == ST_IDLE);

  nsm_tick #(.HALF_CLKS(HALF_CLKS)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .last    (last)
  );

  // decode of the slot about to be presented, so the pins leave flops
  nsm_frame u_frame (
    .is_write (wr_n),
    .addr     (addr_n),
    .wdata    (wdat_n),
    .bit_idx  (bit_n),
    .bit_val  (nxt_val),
    .drive    (nxt_drv),
    .capture  (nxt_capt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      capt_q  <= 1'b0;
      done_q  <= 1'b0;
      sclk_q  <= 1'b1;
      sdo_q   <= 1'b1;
      oe_q    <= 1'b1;
    end else begin
      state_q <= state_n;
      bit_q   <= bit_n;
      wr_q    <= wr_n;
      addr_q  <= addr_n;
      wdat_q  <= wdat_n;
      capt_q  <= nxt_capt;
      done_q  <= (state_q == ST_TAIL) && last;
      sclk_q  <= (state_n != ST_LOW);
      if (state_n == ST_IDLE) begin
        sdo_q <= 1'b1;
        oe_q  <= 1'b1;
      end else begin
        sdo_q <= nxt_val;
        oe_q  <= nxt_drv;
      end
    end
  end

  // sample at the last clock of the high phase, just before the fall
  always_ff @(posedge clk) begin
    if (rst) shreg_q <= '0;
    else if ((state_q == ST_HIGH) && last && capt_q)
      shreg_q <= {shreg_q[NIB_W-2:0], rtc_sdi};
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = done_q;
  assign rsp_rdata  = shreg_q;
  assign rtc_sclk   = sclk_q;
  assign rtc_sdo    = sdo_q;
  assign rtc_sdo_oe = oe_q;

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (rtc_sclk && rtc_sdo && rtc_sdo_oe));

  a_r2_fields_held: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> ($stable(addr_q) && $stable(wr_q) && $stable(wdat_q)));

  a_r4_turn_point: assert property (@(posedge clk) disable iff (rst)
    $fell(rtc_sdo_oe) |-> ((int'(bit_q) == TURN_BIT) && (state_q == ST_HIGH) && !wr_q));

  a_r5_write_drives: assert property (@(posedge clk) disable iff (rst)
    (wr_q && (state_q != ST_IDLE)) |-> rtc_sdo_oe);

  a_r6_low_only_in_phase: assert property (@(posedge clk) disable iff (rst)
    !rtc_sclk |-> (state_q == ST_LOW));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/test_nsm_master.sv
`timescale 1ns/1ps
module test_nsm_master;
  localparam int HALF = 2;
  localparam int NV   = 10;
  // {write, addr, data}; for reads the data field is unused
  localparam logic [8:0] VECS [0:NV-1] = '{
    {1'b1, 4'h3, 4'hA}, {1'b0, 4'h3, 4'h0}, {1'b0, 4'h0, 4'h0},
    {1'b1, 4'hF, 4'h0}, {1'b1, 4'h0, 4'hF}, {1'b0, 4'hF, 4'h0},
    {1'b0, 4'h0, 4'h0}, {1'b1, 4'h9, 4'h6}, {1'b0, 4'h9, 4'h0},
    {1'b0, 4'h6, 4'h0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, rtc_sclk, rtc_sdo, rtc_sdo_oe;
  logic [3:0] rsp_rdata;
  logic rtc_sdi;

  int nchk = 0, nfail = 0;
  logic [3:0] shadow [16];

  always #4 clk = ~clk;

  nsm_master #(.HALF_CLKS(HALF)) i_nsm_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rtc_sclk(rtc_sclk),
    .rtc_sdo(rtc_sdo), .rtc_sdo_oe(rtc_sdo_oe), .rtc_sdi(rtc_sdi)
  );

  // ---------------- device model ----------------
  logic [3:0]  m_mem [16];
  logic [15:0] m_rec;
  int          m_idx, m_nin, m_low, m_lowbad;
  logic        m_prev;
  logic        m_sdi = 1'b0;
  assign rtc_sdi = m_sdi;

  initial for (int i = 0; i < 16; i++) begin
    m_mem[i]  = 4'(i) ^ 4'h5;
    shadow[i] = 4'(i) ^ 4'h5;
  end

  always @(negedge clk) begin
    if (rst) begin
      m_prev = 1'b1; m_idx = 0; m_low = 0; m_sdi = 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        m_idx = 0; m_nin = 0; m_lowbad = 0; m_rec = '0; m_sdi = 1'b0;
      end
      if (!rtc_sclk) m_low++;
      if (m_prev && !rtc_sclk && m_idx < 16) begin
        m_rec[15-m_idx] = rtc_sdo;
        if (!rtc_sdo_oe) m_nin++;
        m_idx++;
        if (m_idx >= 8 && m_idx < 12)
          m_sdi = ~m_mem[m_rec[11:8]][11-m_idx];
        else if (m_idx >= 12 && m_idx < 16)
          m_sdi = m_mem[m_rec[11:8]][15-m_idx];
        else
          m_sdi = 1'b0;
        if (m_idx == 16 && m_rec[14] == 1'b0 && m_rec[7:4] == 4'b1001)
          m_mem[m_rec[11:8]] = m_rec[3:0];
      end
      if (!m_prev && rtc_sclk) begin
        if (m_low != HALF) m_lowbad++;
        m_low = 0;
      end
      m_prev = rtc_sclk;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [3:0] a, input logic [3:0] d,
                      output logic [3:0] rd, output int cyc);
    int guard = 0;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    cyc = 0;
    forever begin
      @(negedge clk);
      if (rsp_valid || guard > 5000) break;
      @(posedge clk);
      cyc++; guard++;
    end
    rd = rsp_rdata;
    @(negedge clk);
    chk("R7 pulse one cycle", rsp_valid, 1'b0);
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " sclk"}, rtc_sclk, 1'b1);
    chk({tag, " sdo"}, rtc_sdo, 1'b1);
    chk({tag, " oe"}, rtc_sdo_oe, 1'b1);
    chk({tag, " ready"}, req_ready, 1'b1);
    chk({tag, " valid"}, rsp_valid, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    nfail++;
    $display("FAIL R7 watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [3:0] rd;
    int cyc;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check_idle("R1 reset");

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic wr; logic [3:0] a, d;
      {wr, a, d} = VECS[v];
      xfer(wr, a, d, rd, cyc);
      chk("R7 latency", cyc, 33 * HALF);
      chk("R6 pulse count", m_idx, 16);
      chk("R6 low width", m_lowbad, 0);
      if (wr) begin
        shadow[a] = d;
        chk("R5 write frame", m_rec, {4'b1010, a, 4'b1001, d});
        chk("R5 oe held", m_nin, 0);
      end else begin
        chk("R3 read header", m_rec[15:8], {4'b1110, a});
        chk("R4 input bits", m_nin, 8);
        chk("R4 read data", rd, shadow[a]);
      end
      check_idle("R1 after frame");
    end

    // R2: request held during a busy frame is ignored
    begin
      logic [3:0] keep;
      keep = shadow[4'h9];
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = 1'b0; req_addr = 4'h9;
      @(posedge clk); #1;
      req_write = 1'b1; req_addr = 4'h9; req_wdata = ~keep;
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk("R2 ready low busy", req_ready, 1'b0);
      #1 req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      chk("R2 busy read data", rsp_rdata, keep);
      repeat (4 * HALF) @(negedge clk);
      chk("R2 no second frame", rtc_sclk, 1'b1);
      chk("R2 still ready", req_ready, 1'b1);
      xfer(1'b0, 4'h9, 4'h0, rd, cyc);
      chk("R2 contents unchanged", rd, keep);
    end

    // R8: reset in the middle of a frame
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h2; req_wdata = 4'hC;
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (20) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check_idle("R8 mid reset");
    xfer(1'b0, 4'h6, 4'h0, rd, cyc);
    chk("R8 recovery data", rd, shadow[4'h6]);
    chk("R8 recovery latency", cyc, 33 * HALF);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule